// File: doc/BRIEF.md
# Filtered Reset Sequencer

This block sits between a board-level reset line and a small 8-bit processor core. It takes the active-low pin level, which may be asynchronous and noisy, brings it into the clock domain through a two-stage synchronizer, and discards lows that are too short to be a real request. A qualified request becomes a clean internal reset. That reset lasts for a guaranteed minimum number of cycles and is extended for as long as the pin stays low.

While the core is held, the block puts fixed patterns on the bus strobes. After it lets go, it waits a short programmable start delay and then issues a one-cycle fetch-start pulse that carries the fixed start vector. An optional power-on timer, started by a power-on indication, pulls the shared open-drain reset line low for a programmed time. While the block is driving the line, it reads the line back as low, so its own drive can never end the sequence early.

A qualified new low that arrives while the hold or the start delay is still running restarts the hold from zero and suppresses the pending fetch-start pulse.

Top module: `rst_filter_seq`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `core_rst`, `pin_drive_en` and `fetch_go` go to 0, `addr_stb` and `data_stb` go to 1, and `fetch_addr` goes to 0.
- R2: A low on `pin_n` that lasts fewer than FILT_CLKS (4) consecutive clocks produces no internal reset.
- R3: For a low of at least FILT_CLKS clocks, `core_rst` is 0 in the sixth cycle after the pin is first sampled low and is 1 in the seventh. This is two synchronizer stages plus the filter count, latching on the fifth clock after detection.
- R4: Once asserted, `core_rst` stays high for at least HOLD_CLKS (18) consecutive cycles.
- R5: While the pin stays low, the hold is extended. For a pin low of L cycles with L-4 above HOLD_CLKS, `core_rst` stays high for L-4 cycles.
- R6: A new qualified low, meaning the fourth consecutive synchronized low cycle, during the hold restarts the hold count from zero on that edge.
- R7: A new qualified low during the start delay reasserts `core_rst` on that edge. It begins a fresh full-length hold, and no `fetch_go` pulse is produced for the abandoned delay.
- R8: While `core_rst` is 1, `data_stb` is 0 and `addr_stb` changes value every cycle. While `core_rst` is 0, both strobes are 1.
- R9: Exactly START_DLY cycles after `core_rst` falls, `fetch_go` is 1 for one cycle, with `fetch_addr` equal to START_ADDR (000Ch). At all other times `fetch_addr` is 0.
- R10: A `pwr_on` pulse makes `pin_drive_en` high for exactly POR_CLKS cycles. During that time the line is treated as low, so `core_rst` lasts max(HOLD_CLKS, POR_CLKS-2) cycles when the pin is wired back to the drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer itself |
| pin_n | input | 1 | Level of the shared reset line, low requests reset |
| pwr_on | input | 1 | Power-on indication, a high cycle starts the power-on timer |
| pin_drive_en | output | 1 | Open-drain enable, 1 pulls the reset line low |
| core_rst | output | 1 | Internal reset to the core, active high |
| addr_stb | output | 1 | Address strobe, toggles while in reset |
| data_stb | output | 1 | Data strobe, held low while in reset |
| fetch_go | output | 1 | One-cycle pulse that starts the first instruction fetch |
| fetch_addr | output | AW (16) | Start vector, valid while `fetch_go` is high |

## Verification
The bench builds the block with START_DLY set to 7 and POR_CLKS set to 30. The filter length, the hold length and the start address keep their default values. A start delay of 7 leaves room to land a qualified new low inside the delay window before the fetch-start pulse would fire. A power-on time of 30 is longer than the hold, so the drive-extended reset length (28) can be told apart from the minimum hold. The long-pin case (30 cycles giving 26) and the double-pulse case (31 cycles) likewise produce lengths that differ from the minimum of 18.

// File: rtl/rfs_pkg.sv
// Shared types for the filtered reset sequencer.
// Assumes nothing beyond standard SystemVerilog enums.
package rfs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // core running, watching the pin
        ST_HOLD  = 2'd1,  // core held in reset
        ST_START = 2'd2   // reset released, counting the start delay
    } rfs_state_e;
endpackage

// File: rtl/rfs_sync.sv
// Multi-stage synchronizer for the asynchronous reset line level.
// Assumes the input is a single-bit level; resets to the idle (high) level.
module rfs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_in};
        end
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/rfs_glitch.sv
// Glitch filter: counts consecutive low cycles and restarts from zero
// whenever the line is seen high. Assumes the input is already synchronous.
module rfs_glitch #(
    parameter int FILT_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_in,
    output logic low_ok,
    output logic new_low
);
    localparam int CW = $clog2(FILT_CLKS + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_CLKS);

    logic [CW-1:0] run_q;

    // Count the low run, saturating at the filter length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!low_in) begin
            run_q <= '0;
        end else if (run_q != FULL) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign low_ok  = (run_q == FULL);
    assign new_low = low_in && (run_q == FULL - 1'b1);
endmodule

// File: rtl/rfs_por.sv
// Optional power-on timer: a pwr_on cycle loads the duration and the line
// is pulled low until it counts out. With POR_EN = 0 the drive stays off.
module rfs_por #(
    parameter bit POR_EN   = 1'b1,
    parameter int POR_CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    output logic drive_en
);
    generate
        if (POR_EN) begin : g_timer
            localparam int PW = $clog2(POR_CLKS + 1);
            logic [PW-1:0] left_q;

            // Load on power-on indication, then count down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    left_q <= '0;
                end else if (pwr_on) begin
                    left_q <= PW'(POR_CLKS);
                end else if (left_q != '0) begin
                    left_q <= left_q - 1'b1;
                end
            end

            assign drive_en = (left_q != '0);
        end else begin : g_none
            logic unused_in;
            assign unused_in = pwr_on ^ clk ^ rst_n;
            assign drive_en  = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/rst_filter_seq.sv
// Top of the filtered reset sequencer. Synchronizes and filters the reset
// line, stretches a qualified request, drives the bus strobes during reset
// and issues the first-fetch pulse after the start delay.
// Assumes clk runs whenever a reset request must be seen.
module rst_filter_seq #(
    parameter int          SYNC_STAGES = 2,
    parameter int          FILT_CLKS   = 4,
    parameter int          HOLD_CLKS   = 18,
    parameter int          START_DLY   = 7,        // legal range 5 to 10
    parameter bit          POR_EN      = 1'b1,
    parameter int          POR_CLKS    = 64,
    parameter int          AW          = 16,
    parameter logic [AW-1:0] START_ADDR = 16'h000C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_n,
    input  logic          pwr_on,
    output logic          pin_drive_en,
    output logic          core_rst,
    output logic          addr_stb,
    output logic          data_stb,
    output logic          fetch_go,
    output logic [AW-1:0] fetch_addr
);
    import rfs_pkg::*;

    localparam int HW = $clog2(HOLD_CLKS + 1);
    localparam int DW = $clog2(START_DLY + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CLKS - 1);
    localparam logic [DW-1:0] DLY_LAST  = DW'(START_DLY - 1);

    logic       pin_sync;
    logic       line_low;
    logic       low_ok;
    logic       new_low;
    logic       drive_en;

    rfs_state_e    state_q;
    logic [HW-1:0] hold_q;
    logic [DW-1:0] dly_q;
    logic          tog_q;
    logic          go_q;

    rfs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_n),
        .q_out (pin_sync)
    );

    rfs_por #(.POR_EN(POR_EN), .POR_CLKS(POR_CLKS)) u_por (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_on   (pwr_on),
        .drive_en (drive_en)
    );

    // The line reads low while this block pulls it, whatever the pin shows.
    assign line_low = !pin_sync || drive_en;

    rfs_glitch #(.FILT_CLKS(FILT_CLKS)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .low_in  (line_low),
        .low_ok  (low_ok),
        .new_low (new_low)
    );

    // Sequence: idle -> hold (stretch) -> start delay -> fetch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
            dly_q   <= '0;
            go_q    <= 1'b0;
        end else begin
            go_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (low_ok) begin
                        state_q <= ST_HOLD;
                        hold_q  <= '0;
                    end
                end
                ST_HOLD: begin
                    if (new_low) begin
                        hold_q <= '0;
                    end else if (hold_q != HOLD_LAST) begin
                        hold_q <= hold_q + 1'b1;
                    end else if (!line_low) begin
                        state_q <= ST_START;
                        dly_q   <= '0;
                    end
                end
                ST_START: begin
                    if (new_low) begin
                        state_q <= ST_HOLD;
                        hold_q  <= '0;
                    end else if (dly_q == DLY_LAST) begin
                        state_q <= ST_IDLE;
                        go_q    <= 1'b1;
                    end else begin
                        dly_q <= dly_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Address strobe toggle: alternates in hold, parks high otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b1;
        end else if (state_q == ST_HOLD) begin
            tog_q <= !tog_q;
        end else begin
            tog_q <= 1'b1;
        end
    end

    assign core_rst     = (state_q == ST_HOLD);
    assign addr_stb     = core_rst ? tog_q : 1'b1;
    assign data_stb     = !core_rst;
    assign fetch_go     = go_q;
    assign fetch_addr   = go_q ? START_ADDR : '0;
    assign pin_drive_en = drive_en;
endmodule

// File: rtl/rfs_chk.sv
// Property checker for the filtered reset sequencer, bound to the top.
// Assumes the top's synchronous active-low rst_n.
module rfs_chk #(
    parameter int            HOLD_CLKS  = 18,
    parameter int            AW         = 16,
    parameter logic [AW-1:0] START_ADDR = 16'h000C
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_rst,
    input logic          addr_stb,
    input logic          data_stb,
    input logic          fetch_go,
    input logic [AW-1:0] fetch_addr
);
    logic [15:0] run_q;

    // Length of the current core_rst high run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!core_rst) begin
            run_q <= '0;
        end else if (run_q != 16'hFFFF) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R4
    min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> run_q >= 16'(HOLD_CLKS));

    // R8
    as_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst && $past(core_rst)) |-> (addr_stb != $past(addr_stb)));

    // R8
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst |-> (addr_stb && data_stb));

    // R9
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |=> !fetch_go);

    // R9
    fetch_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |-> (fetch_addr == START_ADDR && !core_rst));
endmodule

bind rst_filter_seq rfs_chk #(
    .HOLD_CLKS  (HOLD_CLKS),
    .AW         (AW),
    .START_ADDR (START_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst   (core_rst),
    .addr_stb   (addr_stb),
    .data_stb   (data_stb),
    .fetch_go   (fetch_go),
    .fetch_addr (fetch_addr)
);

// File: tb/tb_rst_filter_seq.sv
// Scoreboard bench: stimulus tasks queue the expected reset episodes,
// a negedge monitor measures each episode and compares.
module tb_rst_filter_seq;
    localparam int AW   = 16;
    localparam int DLY  = 7;
    localparam int PORT = 30;

    typedef struct {
        int    len;
        int    gap;
        string req;
    } ep_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pin_ext = 1'b1;
    logic          pwr_on = 1'b0;
    logic          pin_n;
    logic          pin_drive_en, core_rst, addr_stb, data_stb, fetch_go;
    logic [AW-1:0] fetch_addr;

    int   n_chk = 0;
    int   n_bad = 0;
    ep_t  sb[$];
    bit   mon_on = 0, in_rst = 0, waiting = 0, first = 0;
    bit   stb_bad = 0, idle_bad = 0, prev_as = 0;
    int   cur_len = 0, gap_cnt = 0, rises = 0;

    always #2.5 clk = ~clk;

    assign pin_n = pin_ext & ~pin_drive_en;

    rst_filter_seq #(.START_DLY(DLY), .POR_CLKS(PORT)) dut (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .pwr_on(pwr_on),
        .pin_drive_en(pin_drive_en), .core_rst(core_rst),
        .addr_stb(addr_stb), .data_stb(data_stb),
        .fetch_go(fetch_go), .fetch_addr(fetch_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_ep(input int len, input int gap, input string req);
        ep_t e;
        e.len = len; e.gap = gap; e.req = req;
        sb.push_back(e);
    endtask

    task automatic finish_ep(input int gap);
        ep_t e;
        if (sb.size() == 0) begin
            chk(0, "unexpected episode", cur_len, 0);
        end else begin
            e = sb.pop_front();
            chk(cur_len == e.len, {e.req, " reset length"}, cur_len, e.len);
            chk(gap == e.gap, {e.req, " R9 fetch gap"}, gap, e.gap);
            chk(!stb_bad, "R8 strobes in reset", int'(stb_bad), 0);
        end
        stb_bad = 0;
        waiting = 0;
    endtask

    // Monitor: measure each reset episode and its fetch gap.
    always @(negedge clk) begin
        if (mon_on) begin
            if (core_rst) begin
                if (!in_rst) begin
                    if (waiting) finish_ep(-1);
                    in_rst = 1; cur_len = 0; first = 1; rises++;
                end
                cur_len++;
                if (data_stb !== 1'b0) stb_bad = 1;
                if (!first && addr_stb === prev_as) stb_bad = 1;
                prev_as = addr_stb;
                first = 0;
            end else begin
                if (addr_stb !== 1'b1 || data_stb !== 1'b1) idle_bad = 1;
                if (in_rst) begin
                    in_rst = 0; waiting = 1; gap_cnt = 0;
                end else if (waiting) begin
                    gap_cnt++;
                end
                if (fetch_go) begin
                    if (waiting) begin
                        chk(fetch_addr == 16'h000C, "R9 fetch address", int'(fetch_addr), 12);
                        finish_ep(gap_cnt);
                    end else begin
                        chk(0, "R9 stray fetch", 1, 0);
                    end
                end else if (fetch_addr != '0) begin
                    chk(0, "R9 address outside pulse", int'(fetch_addr), 0);
                end
            end
        end
    end

    task automatic low_pulse(input int n);
        pin_ext = 1'b0;
        repeat (n) @(negedge clk);
        pin_ext = 1'b1;
    endtask

    task automatic wait_done();
        while (sb.size() != 0 || waiting || in_rst) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        int r0, cnt;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(core_rst == 0, "R1 core_rst", core_rst, 0);
        chk(pin_drive_en == 0, "R1 pin_drive_en", pin_drive_en, 0);
        chk(fetch_go == 0, "R1 fetch_go", fetch_go, 0);
        chk(addr_stb == 1 && data_stb == 1, "R1 strobes", {addr_stb, data_stb}, 3);
        chk(fetch_addr == 0, "R1 fetch_addr", int'(fetch_addr), 0);
        rst_n = 1'b1; mon_on = 1;
        repeat (5) @(negedge clk);

        // R2 a 3-cycle low is ignored
        r0 = rises;
        low_pulse(3);
        repeat (30) @(negedge clk);
        chk(rises == r0 && core_rst == 0, "R2 short low ignored", rises - r0, 0);

        // R3 latch timing, R4 minimum hold with a 4-cycle low
        push_ep(18, DLY, "R4");
        low_pulse(4);
        repeat (2) @(negedge clk);
        chk(core_rst == 0, "R3 not yet latched", core_rst, 0);
        @(negedge clk);
        chk(core_rst == 1, "R3 latched", core_rst, 1);
        wait_done();

        // R4 a 10-cycle low still gives the minimum hold
        push_ep(18, DLY, "R4");
        low_pulse(10);
        wait_done();

        // R5 a 30-cycle low extends the hold to 26
        push_ep(26, DLY, "R5");
        low_pulse(30);
        wait_done();

        // R6 second qualified low 14 cycles later restarts the hold
        push_ep(31, DLY, "R6");
        low_pulse(4);
        repeat (10) @(negedge clk);
        low_pulse(4);
        wait_done();

        // R7 qualified low during the start delay: no fetch, fresh hold
        push_ep(18, -1, "R7");
        push_ep(18, DLY, "R7");
        low_pulse(4);
        while (!core_rst) @(negedge clk);
        while (core_rst) @(negedge clk);
        low_pulse(4);
        wait_done();

        // R10 power-on timer drives the line for POR_CLKS cycles
        push_ep(PORT - 2, DLY, "R10");
        pwr_on = 1'b1;
        @(negedge clk);
        pwr_on = 1'b0;
        cnt = pin_drive_en ? 1 : 0;
        for (int i = 0; i < 2 * PORT; i++) begin
            @(negedge clk);
            if (pin_drive_en) cnt++;
        end
        chk(cnt == PORT, "R10 drive length", cnt, PORT);
        wait_done();

        chk(!idle_bad, "R8 strobes idle high", int'(idle_bad), 0);
        chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        summary();
    end
endmodule